// File: doc/BRIEF.md
# Register-File Datapath with Operand Buses and ALU

This block is the execution core of a small register-based processor. It holds seven general registers. Each cycle it reads two operands onto a pair of source buses, combines them in an arithmetic/logic unit, and can write the result back into one of the registers. A 14-bit control word supplied every cycle sets the whole datapath. The word carries a selector for each operand bus, a destination selector and an operation code.

An external data input can stand in for either operand, which is how values enter the register file. The ALU output is always visible on the `result` port, so it can be stored, observed, or both. Instruction fetch, decoding and the sequencing of control words are left to the surrounding logic.

Top module: `dp_core`

## Requirements
- R1: While `rst_n` is low, all seven registers are cleared to zero on the clock edge. After release, each reads back as 0.
- R2: For each operand selector, value 0 places `ext_in` on that operand bus, and values 1 to 7 place register 1 to 7 on it. The two selectors work independently.
- R3: The operation codes are: 0 pass A, 1 A+1, 2 A+B, 3 A-B, 4 A-1, 5 A AND B, 6 A OR B, 7 A XOR B, 8 NOT A, 9 A shifted right by one with zero fill, 10 A shifted left by one with zero fill. Arithmetic wraps modulo 2^DATA_W.
- R4: Every operation code from 11 to 31 passes operand A to `result` unchanged.
- R5: When the destination selector is n (1 to 7), register n takes the ALU result at the next rising clock edge. All other registers keep their values, and at most one load line is active.
- R6: When the destination selector is 0, no register changes. The result appears only on `result`.
- R7: A register that is both read and written in the same cycle supplies its old value to the ALU. The new value is seen from the following cycle onward.
- R8: The control word is packed as operand A select [13:11], operand B select [10:8], destination select [7:5] and operation code [4:0].
- R9: `result` follows the current control word, `ext_in` and register contents in the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 14 | Control word: A select, B select, destination select, operation |
| ext_in | input | DATA_W | External data, chosen by select value 0 |
| result | output | DATA_W | ALU output for the current control word |

## Verification
The hardest case to reach from the ports is a register read and written in the same cycle. Once the register is written, its old value is gone, and the register can only be seen again by a later pass operation. The stimulus therefore chains increments and additions that read and write the same register in back-to-back cycles. In each cycle the expected result is built only on the value from the cycle before. Writes with destination 0 are followed at once by pass reads of every register, to show that nothing moved.

// File: rtl/dp_pkg.sv
package dp_pkg;
   localparam int SEL_W  = 3;
   localparam int OP_W   = 5;
   localparam int CTL_W  = 3 * SEL_W + OP_W;
   localparam int NREG   = (1 << SEL_W) - 1;

   typedef enum logic [OP_W-1:0] {
      OP_PASS = 5'd0,
      OP_INC  = 5'd1,
      OP_ADD  = 5'd2,
      OP_SUB  = 5'd3,
      OP_DEC  = 5'd4,
      OP_AND  = 5'd5,
      OP_OR   = 5'd6,
      OP_XOR  = 5'd7,
      OP_NOT  = 5'd8,
      OP_SHR  = 5'd9,
      OP_SHL  = 5'd10
   } alu_op_e;

   // field order is the decode contract with the sequencer
   typedef struct packed {
      logic [SEL_W-1:0] sel_a;
      logic [SEL_W-1:0] sel_b;
      logic [SEL_W-1:0] sel_dst;
      logic [OP_W-1:0]  op;
   } ctl_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NREG:1]                load_en,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [NREG:1][DATA_W-1:0]    regs_q
);
   generate
      for (genvar g = 1; g <= NREG; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_q[g] <= '0;
            else if (load_en[g])
               regs_q[g] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/dp_srcmux.sv
module dp_srcmux #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   localparam int NREG  = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0]            sel,
   input  logic [DATA_W-1:0]           ext_in,
   input  logic [NREG:1][DATA_W-1:0]   regs_q,
   output logic [DATA_W-1:0]           bus_out
);
   always_comb begin
      bus_out = ext_in;
      for (int i = 1; i <= NREG; i++) begin
         if (sel == SEL_W'(i))
            bus_out = regs_q[i];
      end
   end
endmodule

// File: rtl/dp_dstdec.sv
module dp_dstdec #(
   parameter int SEL_W = 3,
   localparam int NREG = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0] sel,
   output logic [NREG:1]    load_en
);
   generate
      for (genvar g = 1; g <= NREG; g++) begin : g_line
         assign load_en[g] = (sel == SEL_W'(g));
      end
   endgenerate
endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_comb begin
      case (op)
         OP_INC:  y = a + ONE;
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_DEC:  y = a - ONE;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~a;
         OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
         OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
         default: y = a;
      endcase
   end
endmodule

// File: rtl/dp_core.sv
module dp_core
   import dp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] result
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dp_core: DATA_W must be at least 2");
      end
      if (CTL_W != 14) begin : g_bad_ctl
         $error("dp_core: control word must be 14 bits");
      end
   endgenerate

   ctl_t                        ctl;
   logic [DATA_W-1:0]           s1_bus;
   logic [DATA_W-1:0]           s2_bus;
   logic [NREG:1]               load_en;
   logic [NREG:1][DATA_W-1:0]   regs_q;

   assign ctl = ctl_t'(ctl_word);

   dp_srcmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux_a (
      .sel(ctl.sel_a), .ext_in(ext_in), .regs_q(regs_q), .bus_out(s1_bus));

   dp_srcmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux_b (
      .sel(ctl.sel_b), .ext_in(ext_in), .regs_q(regs_q), .bus_out(s2_bus));

   dp_alu #(.DATA_W(DATA_W)) u_alu (
      .op(ctl.op), .a(s1_bus), .b(s2_bus), .y(result));

   dp_dstdec #(.SEL_W(SEL_W)) u_dec (
      .sel(ctl.sel_dst), .load_en(load_en));

   dp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .load_en(load_en),
      .wr_data(result), .regs_q(regs_q));
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk
   import dp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CTL_W-1:0]             ctl_word,
   input logic [DATA_W-1:0]            ext_in,
   input logic [DATA_W-1:0]            s1_bus,
   input logic [DATA_W-1:0]            s2_bus,
   input logic [DATA_W-1:0]            result,
   input logic [NREG:1]                load_en,
   input logic [NREG:1][DATA_W-1:0]    regs_q
);
   logic [SEL_W-1:0] sa, sb, sd;
   logic [OP_W-1:0]  op;
   logic [DATA_W-1:0] reg_at [0:NREG];

   assign sa = ctl_word[13:11];
   assign sb = ctl_word[10:8];
   assign sd = ctl_word[7:5];
   assign op = ctl_word[4:0];

   assign reg_at[0] = ext_in;
   generate
      for (genvar g = 1; g <= NREG; g++) begin : g_view
         assign reg_at[g] = regs_q[g];
      end
   endgenerate

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_q == '0));

   p_src_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_bus == reg_at[sa]);

   p_src_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s2_bus == reg_at[sb]);

   p_unused_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op > 5'd10) |-> (result == s1_bus));

   p_one_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_en));

   p_write_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sd != '0) |=> (regs_q[$past(sd)] == $past(result)));

   p_load_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sd != '0) |-> ($countones(load_en) == 1 && load_en[sd]));

   p_no_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sd == '0) |=> $stable(regs_q));
endmodule

bind dp_core dp_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .ext_in(ext_in),
   .s1_bus(s1_bus), .s2_bus(s2_bus), .result(result),
   .load_en(load_en), .regs_q(regs_q));

// File: tb/tb_dp_core.sv
module tb_dp_core;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [13:0]       ctl_word = '0;
   logic [DATA_W-1:0] ext_in = '0;
   logic [DATA_W-1:0] result;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [DATA_W-1:0] exp_q [$];
   string             tag_q [$];
   logic [DATA_W-1:0] mdl [0:7];

   dp_core #(.DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
      .ext_in(ext_in), .result(result));

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [DATA_W-1:0] model_alu(
      input logic [4:0] op, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      case (op)
         5'd1:  return a + 1'b1;
         5'd2:  return a + b;
         5'd3:  return a - b;
         5'd4:  return a - 1'b1;
         5'd5:  return a & b;
         5'd6:  return a | b;
         5'd7:  return a ^ b;
         5'd8:  return ~a;
         5'd9:  return a >> 1;
         5'd10: return a << 1;
         default: return a;
      endcase
   endfunction

   // driver: one control word per cycle, expected result queued for the monitor
   task automatic drive(input logic [2:0] sa, input logic [2:0] sb,
                        input logic [2:0] sd, input logic [4:0] op,
                        input logic [DATA_W-1:0] ext, input string tag);
      logic [DATA_W-1:0] a, b, y;
      @(negedge clk);
      ctl_word = {sa, sb, sd, op};   // R8 packing
      ext_in   = ext;
      a = (sa == 3'd0) ? ext : mdl[sa];
      b = (sb == 3'd0) ? ext : mdl[sb];
      y = model_alu(op, a, b);
      exp_q.push_back(y);
      tag_q.push_back(tag);
      if (sd != 3'd0) mdl[sd] = y;   // visible from next cycle (R7)
   endtask

   task automatic read_all(input string tag);
      for (int i = 1; i <= 7; i++)
         drive(3'(i), 3'd0, 3'd0, 5'd0, 8'h00, tag);
   endtask

   // monitor: compares a quarter period after each drive
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (result !== e) begin
               n_bad++;
               $display("FAIL %s: result=%h expected=%h", t, result, e);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1..: run did not finish, got 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every register reads zero after reset
      read_all("R1 reset value");

      // R2/R5: load registers from external input, then read back
      for (int i = 1; i <= 7; i++)
         drive(3'd0, 3'd0, 3'(i), 5'd0, 8'(8'h11 * i), "R2 ext load");
      read_all("R5 write-back readback");

      // R3: each operation on register pairs and external operand (R9 same cycle)
      drive(3'd1, 3'd2, 3'd0, 5'd2, 8'h00, "R3 add");
      drive(3'd7, 3'd3, 3'd0, 5'd3, 8'h00, "R3 sub");
      drive(3'd2, 3'd7, 3'd0, 5'd3, 8'h00, "R3 sub wrap");
      drive(3'd5, 3'd6, 3'd0, 5'd5, 8'h00, "R3 and");
      drive(3'd5, 3'd0, 3'd0, 5'd6, 8'h0F, "R3 or with ext B");
      drive(3'd0, 3'd4, 3'd0, 5'd7, 8'hA5, "R3 xor with ext A");
      drive(3'd3, 3'd0, 3'd0, 5'd8, 8'h00, "R3 not");
      drive(3'd7, 3'd0, 3'd0, 5'd9, 8'h00, "R3 shr");
      drive(3'd7, 3'd0, 3'd0, 5'd10, 8'h00, "R3 shl");
      drive(3'd0, 3'd0, 3'd0, 5'd1, 8'hFF, "R3 inc wrap");
      drive(3'd0, 3'd0, 3'd0, 5'd4, 8'h00, "R3 dec wrap");
      drive(3'd0, 3'd0, 3'd0, 5'd2, 8'h80, "R3 add ext+ext wrap");

      // R4: unused codes pass A
      drive(3'd4, 3'd1, 3'd0, 5'd11, 8'h00, "R4 op11");
      drive(3'd6, 3'd1, 3'd0, 5'd20, 8'h00, "R4 op20");
      drive(3'd0, 3'd1, 3'd0, 5'd31, 8'h3C, "R4 op31");

      // R6: destination 0 leaves all registers untouched
      drive(3'd1, 3'd1, 3'd0, 5'd8, 8'h00, "R6 no-dest op");
      drive(3'd0, 3'd0, 3'd0, 5'd0, 8'hEE, "R6 no-dest ext");
      read_all("R6 registers unchanged");

      // R7: read and write of the same register in one cycle
      drive(3'd3, 3'd0, 3'd3, 5'd1, 8'h00, "R7 inc self");
      drive(3'd3, 3'd0, 3'd3, 5'd1, 8'h00, "R7 inc self again");
      drive(3'd3, 3'd3, 3'd3, 5'd2, 8'h00, "R7 add self");
      drive(3'd3, 3'd0, 3'd0, 5'd0, 8'h00, "R7 readback");

      // R5: write lands only in its target
      drive(3'd2, 3'd0, 3'd6, 5'd7, 8'h5A, "R5 xor into R6");
      read_all("R5 only target changed");

      // R8/R3: random control words
      for (int k = 0; k < 300; k++)
         drive(3'($urandom), 3'($urandom), 3'($urandom), 5'($urandom_range(0, 12)),
               8'($urandom), "R8 random word");
      read_all("R8 final state");

      // R1: reset mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      read_all("R1 reset after use");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule